// File: doc/BRIEF.md
# Quad Recirculating Serial Shift Register

This block holds four independent serial shift registers, called lanes A to D. Each lane is 64 stages deep. Each lane has its own serial input, its own shift strobe and its own serial output. The output is taken from the last stage. All four lanes run on one common clock. A lane moves its data one stage towards its output only in a clock cycle in which its strobe is high. This lets the four lanes behave as if each had its own clock.

A multiplexer chooses what enters the first stage of each lane. It can take the lane's own output, so the stored pattern circulates without loss, or it can take the external serial input. Two recirculate controls drive these multiplexers. One serves the pair A/B and the other serves the pair C/D.

Typical uses are bit-serial data storage and fixed delay lines. A longer delay is built outside the block by wiring one lane's output to the next lane's input.

Top module: `quad_recirc_shreg`

## Requirements
- R1: A bit that enters stage 1 of a lane appears on that lane's `ser_out` right after the 64th shift of that lane, counting the shift that loaded it as the first.
- R2: A lane whose `shift_en` bit is high in a cycle moves every stage one place towards the output at that clock edge. The content of stage 64 drives `ser_out`.
- R3: When a lane shifts with its pair's `recirc` bit at 1, stage 1 takes the value that `ser_out` of the same lane held before the edge.
- R4: When a lane shifts with its pair's `recirc` bit at 0, stage 1 takes the lane's `ser_in` bit.
- R5: Lane index 0 is A, 1 is B, 2 is C and 3 is D. `recirc[0]` governs lanes 0 and 1, and `recirc[1]` governs lanes 2 and 3.
- R6: After 64 shifts in recirculate mode, a lane holds exactly its earlier contents. A second 64-shift pass therefore produces the same output sequence as the first.
- R7: Shifting one lane never changes the stages of any other lane.
- R8: A lane whose `shift_en` bit is low keeps all 64 stages unchanged, whatever its `ser_in` and `recirc` inputs do.
- R9: The reset is synchronous and active low. A clock edge with `rst_n` at 0 clears every stage of all four lanes, even when strobes are high. After that edge every `ser_out` reads 0.
- R10: Wire lane A's output to lane B's input outside the block and hold `recirc[0]` at 0. A bit entering lane A then appears on lane B's output right after the 128th common shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all stages update on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of all stages |
| ser_in | input | 4 | Serial data input per lane (bit 0 = lane A) |
| shift_en | input | 4 | Per-lane shift strobe (bit 0 = lane A) |
| recirc | input | 2 | Recirculate select per lane pair (bit 0 = A/B, bit 1 = C/D) |
| ser_out | output | 4 | Serial output per lane, the last stage (bit 0 = lane A) |

## Verification
The embedded properties assume that `rst_n`, `shift_en`, `recirc` and `ser_in` hold known values at every rising edge and change only between edges. This mirrors the setup and hold rule on the recirculate and data pins. The properties also assume that reset is driven low from time zero. The bench meets these assumptions by holding reset low from the start and by changing every input one time unit after a rising edge. In the hold phases it toggles data and recirculate inputs freely, but only away from the edge.

// File: rtl/qrs_pkg.sv
// Package: shared constants and types for the quad recirculating shift register.
// Assumes lanes are grouped in pairs that share one recirculate select.
package qrs_pkg;
    localparam int unsigned LANES_PER_PAIR = 2;

    // Source of stage 1 for a lane.
    typedef enum logic {
        FEED_EXTERNAL = 1'b0,
        FEED_LOOPBACK = 1'b1
    } feed_src_e;
endpackage

// File: rtl/qrs_lane.sv
// Module: one serial shift lane of DEPTH stages with an input multiplexer.
// stg[0] is stage 1 and stg[DEPTH-1] is the last stage, which drives ser_out.
// Assumes DEPTH >= 2, a synchronous active-low reset and a single clock.
module qrs_lane
    import qrs_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift,
    input  feed_src_e feed_sel,
    input  logic      din,
    output logic      dout
);
    localparam int unsigned TOP = DEPTH - 1;

    logic [TOP:0] stg;
    logic         feed_bit;

    // Choose the bit that enters stage 1: the lane's own output or the external input.
    always_comb begin
        unique case (feed_sel)
            FEED_LOOPBACK: feed_bit = stg[TOP];
            default:       feed_bit = din;
        endcase
    end

    // Clear on reset, otherwise move the lane one place when strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else if (shift) begin
            stg <= {stg[TOP-1:0], feed_bit};
        end
    end

    // The last stage is the serial output.
    assign dout = stg[TOP];

    // R9: a reset edge leaves every stage at zero.
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (stg == '0));

    // R8: no strobe, no change.
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(stg));

    // R2: a strobed lane moves each stage one place towards the output.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (stg[TOP:1] == $past(stg[TOP-1:0])));

    // R3: in loopback, stage 1 receives the previous output.
    p_loopback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && feed_sel == FEED_LOOPBACK) |=> (stg[0] == $past(dout)));

    // R4: in load mode, stage 1 receives the external bit.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && feed_sel == FEED_EXTERNAL) |=> (stg[0] == $past(din)));
endmodule

// File: rtl/qrs_pair.sv
// Module: two lanes that share one recirculate select.
// Each lane keeps its own strobe, input and output; only the feed select is common.
module qrs_pair
    import qrs_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      recirc,
    input  logic [LANES_PER_PAIR-1:0] shift,
    input  logic [LANES_PER_PAIR-1:0] din,
    output logic [LANES_PER_PAIR-1:0] dout
);
    feed_src_e pair_sel;

    // Map the pair's recirculate bit onto the feed-source encoding.
    always_comb begin
        pair_sel = recirc ? FEED_LOOPBACK : FEED_EXTERNAL;
    end

    for (genvar g = 0; g < LANES_PER_PAIR; g++) begin : g_lane
        qrs_lane #(.DEPTH(DEPTH)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift    (shift[g]),
            .feed_sel (pair_sel),
            .din      (din[g]),
            .dout     (dout[g])
        );
    end

    // R7: with both lanes idle, neither output moves.
    p_pair_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift == '0) |=> $stable(dout));
endmodule

// File: rtl/quad_recirc_shreg.sv
// Module: top level, four serial lanes organised as NUM_PAIRS pairs.
// Bit i of ser_in, shift_en and ser_out belongs to lane i; recirc bit p serves lanes 2p and 2p+1.
// Assumes all inputs are synchronous to clk.
module quad_recirc_shreg
    import qrs_pkg::*;
#(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned NUM_PAIRS = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_PAIRS*LANES_PER_PAIR-1:0]     ser_in,
    input  logic [NUM_PAIRS*LANES_PER_PAIR-1:0]     shift_en,
    input  logic [NUM_PAIRS-1:0]                    recirc,
    output logic [NUM_PAIRS*LANES_PER_PAIR-1:0]     ser_out
);
    localparam int unsigned NUM_LANES = NUM_PAIRS * LANES_PER_PAIR;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        qrs_pair #(.DEPTH(DEPTH)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .recirc (recirc[p]),
            .shift  (shift_en[p*LANES_PER_PAIR +: LANES_PER_PAIR]),
            .din    (ser_in[p*LANES_PER_PAIR +: LANES_PER_PAIR]),
            .dout   (ser_out[p*LANES_PER_PAIR +: LANES_PER_PAIR])
        );
    end

    // R9: every output reads zero after a reset edge.
    p_outputs_zero_r9: assert property (@(posedge clk)
        !rst_n |=> (ser_out == '0));

    // R8: with every strobe low, all outputs hold.
    p_all_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en == '0) |=> $stable(ser_out));

    initial begin
        assert (NUM_LANES >= 1 && DEPTH >= 2);
    end
endmodule

// File: tb/quad_recirc_shreg_test.sv
// Bench: drives the four lanes through load, recirculate, hold, independence,
// pair mapping, cascade and reset phases. A 64-bit bench model per lane is
// built from the requirements, and the outputs are checked after every edge.
module quad_recirc_shreg_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int LANES      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] ser_in = '0;
    logic [LANES-1:0] shift_en = '0;
    logic [1:0]       recirc = '0;
    logic [LANES-1:0] ser_out;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          cascade = 1'b0;
    bit          done    = 1'b0;

    logic [DEPTH-1:0] mdl  [LANES];
    logic [DEPTH-1:0] seq1 [LANES];
    logic [DEPTH-1:0] seq2 [LANES];

    quad_recirc_shreg #(.DEPTH(DEPTH), .NUM_PAIRS(2)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .shift_en (shift_en),
        .recirc   (recirc),
        .ser_out  (ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: drive the inputs, wait for the edge, update the model, compare all lanes.
    task automatic step(input logic [3:0] en, input logic [1:0] rc, input logic [3:0] din,
                        input logic rl, input string tag);
        logic [3:0] d;
        logic       fb;
        d = din;
        if (cascade) d[1] = ser_out[0];
        shift_en = en; recirc = rc; ser_in = d; rst_n = rl;
        @(posedge clk); #1;
        for (int l = 0; l < LANES; l++) begin
            if (!rl) mdl[l] = '0;
            else if (en[l]) begin
                fb = rc[l/2] ? mdl[l][DEPTH-1] : d[l];
                mdl[l] = {mdl[l][DEPTH-2:0], fb};
            end
        end
        for (int l = 0; l < LANES; l++)
            check(ser_out[l] === mdl[l][DEPTH-1], tag, 64'(ser_out[l]), 64'(mdl[l][DEPTH-1]));
    endtask

    function automatic logic pat(input int k, input int l);
        return 1'(((k * (2*l + 3) + l) % 5) < 2);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        for (int l = 0; l < LANES; l++) mdl[l] = '0;
        #1;
        // R9: reset with all strobes high clears everything.
        step(4'hF, 2'b00, 4'hF, 1'b0, "R9 reset");
        check(ser_out === 4'h0, "R9 outputs zero", 64'(ser_out), 64'h0);
        // R9: a full loopback pass after reset shows only zeros.
        for (int k = 0; k < DEPTH; k++) begin
            step(4'hF, 2'b11, 4'hF, 1'b1, "R9 cleared contents");
            check(ser_out === 4'h0, "R9 cleared pass", 64'(ser_out), 64'h0);
        end

        // R4 and R2: load distinct patterns into every lane.
        for (int k = 0; k < DEPTH; k++) begin
            for (int l = 0; l < LANES; l++) d[l] = pat(k, l);
            step(4'hF, 2'b00, d, 1'b1, "R4 load");
        end
        // R1: the first loaded bit is on the output right after shift 64.
        for (int l = 0; l < LANES; l++)
            check(ser_out[l] === pat(0, l), "R1 64-shift latency", 64'(ser_out[l]), 64'(pat(0, l)));

        // R3 and R6: two loopback passes must give identical output sequences.
        for (int k = 0; k < DEPTH; k++) begin
            step(4'hF, 2'b11, ~ser_in, 1'b1, "R3 loopback");
            for (int l = 0; l < LANES; l++) seq1[l][k] = ser_out[l];
        end
        for (int k = 0; k < DEPTH; k++) begin
            step(4'hF, 2'b11, 4'h5, 1'b1, "R3 loopback second pass");
            for (int l = 0; l < LANES; l++) seq2[l][k] = ser_out[l];
        end
        for (int l = 0; l < LANES; l++)
            check(seq1[l] === seq2[l], "R6 contents restored", seq2[l], seq1[l]);

        // R8: strobes low, inputs and recirculate toggling, outputs hold.
        d = ser_out;
        for (int k = 0; k < 20; k++) begin
            step(4'h0, 2'(k), 4'(k * 7), 1'b1, "R8 hold");
            check(ser_out === d, "R8 outputs held", 64'(ser_out), 64'(d));
        end
        // R8: the held contents are still intact in full.
        for (int k = 0; k < DEPTH; k++) step(4'hF, 2'b11, 4'hA, 1'b1, "R8 contents intact");

        // R7: only lane C shifts; the model checks that the other lanes stay put.
        for (int k = 0; k < 10; k++) step(4'b0100, 2'b00, 4'(k), 1'b1, "R7 independence");
        for (int k = 0; k < 5; k++)  step(4'b1001, 2'b10, 4'hF, 1'b1, "R7 independence mixed");

        // R5: recirc[0] loops A/B while C/D load ones; then the reverse.
        for (int k = 0; k < DEPTH; k++) step(4'hF, 2'b01, 4'hF, 1'b1, "R5 pair A/B loop");
        for (int k = 0; k < 3; k++) step(4'hF, 2'b10, 4'h0, 1'b1, "R5 pair C/D loop");
        check(ser_out[3:2] === 2'b11, "R5 C/D filled with ones", 64'(ser_out[3:2]), 64'h3);

        // R10: cascade A into B; a single 1 emerges from B after 128 shifts.
        step(4'hF, 2'b00, 4'h0, 1'b0, "R9 reset before cascade");
        cascade = 1'b1;
        for (int k = 1; k <= 2*DEPTH + 4; k++) begin
            step(4'b0011, 2'b00, {3'b000, 1'(k == 1)}, 1'b1, "R10 cascade");
            check(ser_out[1] === 1'(k == 2*DEPTH), "R10 128-stage delay", 64'(ser_out[1]), 64'(k == 2*DEPTH));
        end
        cascade = 1'b0;

        // R9: reset in mid-run after filling with ones.
        for (int k = 0; k < DEPTH; k++) step(4'hF, 2'b00, 4'hF, 1'b1, "R4 fill ones");
        check(ser_out === 4'hF, "R4 outputs ones", 64'(ser_out), 64'hF);
        step(4'hF, 2'b11, 4'hF, 1'b0, "R9 mid-run reset");
        for (int k = 0; k < DEPTH; k++) begin
            step(4'hF, 2'b11, 4'hF, 1'b1, "R9 after mid-run reset");
            check(ser_out === 4'h0, "R9 zeros after reset", 64'(ser_out), 64'h0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule